// File: doc/BRIEF.md
# Low-Power Mode Wakeup Controller

This controller sequences a USB device controller between a normal running mode and two low-power modes, suspend and standby. Firmware asks for a mode by writing a mode code. In suspend, every clock is gated except the PHY clock, which keeps running. PLL, transceiver and core power all stay on, so the core can carry on where it stopped. In standby, the clocks, the PLL enable, the transceiver enable and core power are all dropped, and the core must restart from reset when it wakes.

Each low-power mode watches its own set of wakeup sources after a two-flop synchronizer:
- **Suspend** watches the D+ and D- lines (a change against the value captured at entry), a SuperSpeed resume indication, VBUS, the CTS input at a programmable level, and the external reset request.
- **Standby** watches only VBUS, CTS and the external reset request.

When a wake is accepted, the cause is recorded one bit per source. A one-cycle pulse then tells the core either to resume in place or to restart. A standby wake first passes through a lock wait: the PLL is re-enabled, and the clocks are held off for a minimum number of cycles and until the PLL reports lock.

**States:**
- `ST_ACTIVE`: running.
- `ST_SUSP_PEND`: suspend requested, waiting for the transactions-idle input.
- `ST_SUSPEND`: suspended.
- `ST_STANDBY`: in standby.
- `ST_LOCK_WAIT`: PLL relock after a standby wake.
- `ST_RESUME`: one cycle; in-place wake.
- `ST_RESTART`: one cycle; reset-style wake.

**Transitions:**
- ACTIVE → SUSP_PEND on a suspend write.
- ACTIVE → STANDBY on a standby write.
- SUSP_PEND → SUSPEND when transactions are idle.
- SUSP_PEND → ACTIVE on an active write (cancel).
- SUSPEND → RESUME on a wake without the reset source.
- SUSPEND → RESTART on a wake that includes the reset source.
- STANDBY → LOCK_WAIT on a wake.
- LOCK_WAIT → RESTART when the lock conditions are met.
- RESUME → ACTIVE and RESTART → ACTIVE after one cycle.

Top module: `lpw_ctrl`

## Requirements
- R1: After reset the controller is in ACTIVE. All five enables (core clock, PHY clock, PLL, transceiver, core power) are high, both pulses are low, `wake_cause` is 0 and `cur_mode` is 0.
- R2: A write of mode code 01 moves ACTIVE to SUSP_PEND. The mode switches to suspend on the first clock edge with `txn_idle` high. While `txn_idle` is low the controller never enters suspend.
- R3: In suspend the core clock enable is low. The PHY clock, PLL, transceiver and core power enables stay high.
- R4: A write of mode code 10 in ACTIVE enters standby on the next edge. In standby all five enables are low.
- R5: In suspend, any of the following wakes the controller on the third clock edge after the input changes:
  - a change of `dp_in` against its value at entry;
  - a change of `dm_in` against its value at entry;
  - `ss_resume` high;
  - `vbus_det` high;
  - `uart_cts` at the active level;
  - `ext_reset` high.
- R6: In standby, `dp_in`, `dm_in` and `ss_resume` have no effect. Only `vbus_det`, the CTS level or `ext_reset` wake it, on the third edge.
- R7: CTS wakes when `uart_cts` equals the polarity bit. The polarity bit is written through `pol_wr`/`pol_val` and resets to 0, which means active-low.
- R8: A suspend wake without the reset source gives a single-cycle `core_resume`. Any wake that includes `ext_reset` gives a single-cycle `core_restart`. The two pulses never coincide.
- R9: A standby wake enters LOCK_WAIT. In LOCK_WAIT the PLL, transceiver and core power enables are high and both clock enables are low. The wait lasts at least `LOCK_MIN` cycles and until `pll_lock` is high; then `core_restart` pulses and all enables return. `pll_lock` is taken as synchronous.
- R10: `wake_cause` uses bits 0 = D+, 1 = D-, 2 = SS resume, 3 = VBUS, 4 = CTS, 5 = reset. At a wake, every enabled source active that cycle is OR-ed in. Writing ones on `cause_clr` clears those bits. A set and a clear of the same bit in one cycle leaves the bit set.
- R11: Mode writes are ignored in SUSPEND, STANDBY and LOCK_WAIT. Code 11 is ignored in every state. Code 00 in SUSP_PEND cancels the request back to ACTIVE.
- R12: `cur_mode` reads 01 in SUSPEND, 10 in STANDBY and LOCK_WAIT, and 00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Requested mode code |
| pol_wr | input | 1 | CTS polarity write strobe |
| pol_val | input | 1 | CTS active level to store |
| cause_clr | input | 6 | Write-one-to-clear mask for wake_cause |
| txn_idle | input | 1 | High when no transaction is outstanding |
| dp_in | input | 1 | D+ line level |
| dm_in | input | 1 | D- line level |
| ss_resume | input | 1 | SuperSpeed receive resume indication |
| vbus_det | input | 1 | VBUS present |
| uart_cts | input | 1 | UART CTS input |
| ext_reset | input | 1 | External reset request, active high |
| pll_lock | input | 1 | PLL lock indication |
| clk_en_core | output | 1 | Core and system clock enable |
| clk_en_phy | output | 1 | PHY clock enable |
| pll_en | output | 1 | PLL enable |
| xcvr_en | output | 1 | USB transceiver enable |
| core_pwr_en | output | 1 | Core power enable |
| core_resume | output | 1 | One-cycle in-place wake pulse |
| core_restart | output | 1 | One-cycle reset-style wake pulse |
| cur_mode | output | 2 | Current mode code |
| wake_cause | output | 6 | Sticky wake cause bits |

## Verification
Two functions can act in the same cycle.

The first is the cause register being set by a wake and cleared by software. The bench leaves the VBUS cause bit set from an earlier wake. It then wakes from suspend by VBUS again, and drives a `cause_clr` of that bit timed to land on the exact edge where the wake is taken. The bit must read 1 afterwards, and a later plain clear must take it to 0.

The second is several sources hitting at the same edge. The bench drives `ss_resume` and `vbus_det` together. It also drives `ext_reset` together with a line change. It checks the combined cause mask, and checks that reset wins the choice of pulse.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    localparam int NSRC = 6;

    localparam int SRC_DP   = 0;
    localparam int SRC_DM   = 1;
    localparam int SRC_SS   = 2;
    localparam int SRC_VBUS = 3;
    localparam int SRC_CTS  = 4;
    localparam int SRC_RST  = 5;

    localparam logic [1:0] MODE_ACTIVE  = 2'b00;
    localparam logic [1:0] MODE_SUSPEND = 2'b01;
    localparam logic [1:0] MODE_STANDBY = 2'b10;

    localparam logic [NSRC-1:0] SUSP_WAKE_MASK = 6'b111111;
    localparam logic [NSRC-1:0] STBY_WAKE_MASK = 6'b111000;

    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_SUSP_PEND = 3'd1,
        ST_SUSPEND   = 3'd2,
        ST_STANDBY   = 3'd3,
        ST_LOCK_WAIT = 3'd4,
        ST_RESUME    = 3'd5,
        ST_RESTART   = 3'd6
    } lpw_state_e;

    typedef struct packed {
        logic clk_core;
        logic clk_phy;
        logic pll;
        logic xcvr;
        logic pwr;
    } lpw_en_t;

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lpw_wake_detect.sv
module lpw_wake_detect
    import lpw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_sync,
    input  logic            cts_pol,
    input  logic            capture,
    input  logic            in_suspend,
    input  logic            in_standby,
    output logic [NSRC-1:0] hits
);
    logic [1:0]      line_base_q;
    logic [NSRC-1:0] active_src;
    logic [NSRC-1:0] mode_mask;

    // Line levels captured on the edge that enters suspend
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       line_base_q <= '0;
        else if (capture) line_base_q <= src_sync[SRC_DM:SRC_DP];
    end

    always_comb begin
        active_src           = '0;
        active_src[SRC_DP]   = src_sync[SRC_DP] ^ line_base_q[0];
        active_src[SRC_DM]   = src_sync[SRC_DM] ^ line_base_q[1];
        active_src[SRC_SS]   = src_sync[SRC_SS];
        active_src[SRC_VBUS] = src_sync[SRC_VBUS];
        active_src[SRC_CTS]  = (src_sync[SRC_CTS] == cts_pol);
        active_src[SRC_RST]  = src_sync[SRC_RST];
    end

    always_comb begin
        mode_mask = '0;
        if (in_suspend) mode_mask = SUSP_WAKE_MASK;
        if (in_standby) mode_mask = STBY_WAKE_MASK;
    end

    assign hits = active_src & mode_mask;

    AST_ONE_LOW_POWER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_suspend, in_standby})); // R12
endmodule

// File: rtl/lpw_lock_wait.sv
module lpw_lock_wait #(
    parameter int LOCK_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pll_lock,
    output logic done
);
    localparam int CW = $clog2(LOCK_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_MIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && pll_lock && (cnt_q == LAST);

    AST_LOCK_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0); // R9
endmodule

// File: rtl/lpw_cause_reg.sv
module lpw_cause_reg
    import lpw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] cause
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~clr) | set;
    end

    AST_CAUSE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((cause & $past(set)) == $past(set))); // R10
endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
    import lpw_pkg::*;
#(
    parameter int LOCK_MIN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       pol_wr,
    input  logic       pol_val,
    input  logic [5:0] cause_clr,
    input  logic       txn_idle,
    input  logic       dp_in,
    input  logic       dm_in,
    input  logic       ss_resume,
    input  logic       vbus_det,
    input  logic       uart_cts,
    input  logic       ext_reset,
    input  logic       pll_lock,
    output logic       clk_en_core,
    output logic       clk_en_phy,
    output logic       pll_en,
    output logic       xcvr_en,
    output logic       core_pwr_en,
    output logic       core_resume,
    output logic       core_restart,
    output logic [1:0] cur_mode,
    output logic [5:0] wake_cause
);
    lpw_state_e      state_q, state_d;
    logic [NSRC-1:0] src_raw, src_sync, hits;
    logic            pol_q;
    logic            wake_any, lock_done;
    logic            in_susp, in_stby, enter_susp;
    lpw_en_t         en;

    assign src_raw = {ext_reset, uart_cts, vbus_det, ss_resume, dm_in, dp_in};

    lpw_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_raw),
        .q     (src_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pol_q <= 1'b0;
        else if (pol_wr) pol_q <= pol_val;
    end

    assign in_susp    = (state_q == ST_SUSPEND);
    assign in_stby    = (state_q == ST_STANDBY);
    assign enter_susp = (state_q == ST_SUSP_PEND) && txn_idle;

    lpw_wake_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sync   (src_sync),
        .cts_pol    (pol_q),
        .capture    (enter_susp),
        .in_suspend (in_susp),
        .in_standby (in_stby),
        .hits       (hits)
    );

    assign wake_any = |hits;

    lpw_lock_wait #(.LOCK_MIN(LOCK_MIN)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_LOCK_WAIT),
        .pll_lock (pll_lock),
        .done     (lock_done)
    );

    lpw_cause_reg u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hits),
        .clr   (cause_clr),
        .cause (wake_cause)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (cfg_wr && cfg_mode == MODE_SUSPEND)      state_d = ST_SUSP_PEND;
                else if (cfg_wr && cfg_mode == MODE_STANDBY) state_d = ST_STANDBY;
            end
            ST_SUSP_PEND: begin
                if (cfg_wr && cfg_mode == MODE_ACTIVE) state_d = ST_ACTIVE;
                else if (txn_idle)                     state_d = ST_SUSPEND;
            end
            ST_SUSPEND: begin
                if (wake_any) state_d = hits[SRC_RST] ? ST_RESTART : ST_RESUME;
            end
            ST_STANDBY: begin
                if (wake_any) state_d = ST_LOCK_WAIT;
            end
            ST_LOCK_WAIT: begin
                if (lock_done) state_d = ST_RESTART;
            end
            ST_RESUME:  state_d = ST_ACTIVE;
            ST_RESTART: state_d = ST_ACTIVE;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    // Output decode
    always_comb begin
        en           = '{clk_core: 1'b1, clk_phy: 1'b1, pll: 1'b1, xcvr: 1'b1, pwr: 1'b1};
        cur_mode     = MODE_ACTIVE;
        core_resume  = 1'b0;
        core_restart = 1'b0;
        unique case (state_q)
            ST_ACTIVE, ST_SUSP_PEND: ;
            ST_SUSPEND: begin
                en.clk_core = 1'b0;
                cur_mode    = MODE_SUSPEND;
            end
            ST_STANDBY: begin
                en       = '0;
                cur_mode = MODE_STANDBY;
            end
            ST_LOCK_WAIT: begin
                en.clk_core = 1'b0;
                en.clk_phy  = 1'b0;
                cur_mode    = MODE_STANDBY;
            end
            ST_RESUME:  core_resume  = 1'b1;
            ST_RESTART: core_restart = 1'b1;
            default: ;
        endcase
    end

    assign clk_en_core = en.clk_core;
    assign clk_en_phy  = en.clk_phy;
    assign pll_en      = en.pll;
    assign xcvr_en     = en.xcvr;
    assign core_pwr_en = en.pwr;

    AST_SUSP_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP_PEND && !txn_idle) |=> state_q != ST_SUSPEND); // R2

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_resume && core_restart)); // R8

    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_restart |=> !core_restart); // R8

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_resume |=> !core_resume); // R8

    AST_CLOCKS_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK_WAIT && !pll_lock) |=> !clk_en_core); // R9

    AST_STBY_STAYS_WITHOUT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && hits == '0) |=> cur_mode == MODE_STANDBY); // R6
endmodule

// File: tb/lpw_ctrl_bench.sv
module lpw_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       pol_wr = 1'b0, pol_val = 1'b0;
    logic [5:0] cause_clr = '0;
    logic       txn_idle = 1'b1;
    logic       dp_in = 1'b1, dm_in = 1'b0, ss_resume = 1'b0, vbus_det = 1'b0;
    logic       uart_cts = 1'b1, ext_reset = 1'b0, pll_lock = 1'b1;
    logic       clk_en_core, clk_en_phy, pll_en, xcvr_en, core_pwr_en;
    logic       core_resume, core_restart;
    logic [1:0] cur_mode;
    logic [5:0] wake_cause;

    localparam int LOCK_MIN = 4;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    lpw_ctrl #(.LOCK_MIN(LOCK_MIN)) u_lpw_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .pol_wr(pol_wr), .pol_val(pol_val), .cause_clr(cause_clr),
        .txn_idle(txn_idle), .dp_in(dp_in), .dm_in(dm_in),
        .ss_resume(ss_resume), .vbus_det(vbus_det), .uart_cts(uart_cts),
        .ext_reset(ext_reset), .pll_lock(pll_lock),
        .clk_en_core(clk_en_core), .clk_en_phy(clk_en_phy), .pll_en(pll_en),
        .xcvr_en(xcvr_en), .core_pwr_en(core_pwr_en),
        .core_resume(core_resume), .core_restart(core_restart),
        .cur_mode(cur_mode), .wake_cause(wake_cause)
    );

    function automatic logic [4:0] ens();
        return {clk_en_core, clk_en_phy, pll_en, xcvr_en, core_pwr_en};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] m);
        cfg_mode = m; cfg_wr = 1'b1;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    // Wait for either pulse; returns cycle count and which pulse (1 resume, 2 restart)
    task automatic wait_pulse(output int cnt, output int kind);
        cnt = 0; kind = 0;
        for (int i = 1; i <= 40; i++) begin
            tick(1);
            if (core_resume || core_restart) begin
                cnt = i; kind = core_restart ? 2 : 1;
                break;
            end
        end
    endtask

    task automatic drive_src(input int s, input logic on);
        case (s)
            0: dp_in     = on ? 1'b0 : 1'b1;
            1: dm_in     = on ? 1'b1 : 1'b0;
            2: ss_resume = on;
            3: vbus_det  = on;
            4: uart_cts  = on ? 1'b0 : 1'b1;
            default: ext_reset = on;
        endcase
    endtask

    task automatic enter_suspend();
        write_mode(2'b01);
        tick(1);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cnt, kind;
        tick(3);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        check("R1", "enables", 32'(ens()), 32'h1F);
        check("R1", "cause", 32'(wake_cause), 0);
        check("R1", "pulses", 32'({core_resume, core_restart}), 0);
        check("R12", "mode active", 32'(cur_mode), 0);

        // R2 suspend waits for idle
        txn_idle = 1'b0;
        write_mode(2'b01);
        tick(3);
        check("R2", "held pending", 32'(cur_mode), 0);
        txn_idle = 1'b1;
        tick(1);
        check("R2", "entered suspend", 32'(cur_mode), 1);
        check("R3", "suspend enables", 32'(ens()), 32'h0F);

        // R11 writes ignored in suspend
        write_mode(2'b00);
        write_mode(2'b10);
        tick(3);
        check("R11", "suspend ignores writes", 32'(cur_mode), 1);
        drive_src(3, 1'b1);
        wait_pulse(cnt, kind);
        drive_src(3, 1'b0);
        cause_clr = 6'h3F; tick(1); cause_clr = '0;
        tick(4);

        // R5 R8 R10 sweep of every suspend wake source
        for (int s = 0; s < 6; s++) begin
            enter_suspend();
            drive_src(s, 1'b1);
            wait_pulse(cnt, kind);
            check("R5", $sformatf("suspend latency src%0d", s), 32'(cnt), 3);
            check("R8", $sformatf("pulse kind src%0d", s), 32'(kind), (s == 5) ? 2 : 1);
            tick(1);
            check("R8", "pulse single", 32'({core_resume, core_restart}), 0);
            check("R10", $sformatf("cause src%0d", s), 32'(wake_cause), 32'(1 << s));
            check("R3", "enables restored", 32'(ens()), 32'h1F);
            cause_clr = 6'h3F; tick(1); cause_clr = '0;
            check("R10", "cleared", 32'(wake_cause), 0);
            drive_src(s, 1'b0);
            tick(4);
        end

        // R10 simultaneous sources, reset wins pulse choice
        enter_suspend();
        ss_resume = 1'b1; vbus_det = 1'b1;
        wait_pulse(cnt, kind);
        check("R10", "ss+vbus cause", 32'(wake_cause), 32'h0C);
        ss_resume = 1'b0; vbus_det = 1'b0;
        cause_clr = 6'h3F; tick(1); cause_clr = '0;
        tick(4);
        enter_suspend();
        ext_reset = 1'b1; dm_in = 1'b1;
        wait_pulse(cnt, kind);
        check("R8", "reset with line gives restart", 32'(kind), 2);
        check("R10", "reset+dm cause", 32'(wake_cause), 32'h22);
        ext_reset = 1'b0; dm_in = 1'b0;
        cause_clr = 6'h3F; tick(1); cause_clr = '0;
        tick(4);

        // R10 set and clear in the same cycle: set wins
        enter_suspend();
        vbus_det = 1'b1;
        wait_pulse(cnt, kind);
        vbus_det = 1'b0;
        tick(4);
        enter_suspend();
        vbus_det = 1'b1;
        tick(2);
        cause_clr = 6'h08; tick(1); cause_clr = '0;
        check("R10", "set wins over clear", 32'(wake_cause), 32'h08);
        tick(1);
        cause_clr = 6'h08; tick(1); cause_clr = '0;
        check("R10", "plain clear", 32'(wake_cause), 0);
        vbus_det = 1'b0;
        tick(4);

        // R7 CTS polarity high
        uart_cts = 1'b0;
        pol_val = 1'b1; pol_wr = 1'b1; tick(1); pol_wr = 1'b0;
        tick(3);
        enter_suspend();
        tick(4);
        check("R7", "low cts no wake at pol 1", 32'(cur_mode), 1);
        uart_cts = 1'b1;
        wait_pulse(cnt, kind);
        check("R7", "high cts wakes", 32'(cnt), 3);
        check("R7", "cts cause", 32'(wake_cause), 32'h10);
        uart_cts = 1'b0;
        pol_val = 1'b0; pol_wr = 1'b1; tick(1); pol_wr = 1'b0;
        uart_cts = 1'b1;
        cause_clr = 6'h3F; tick(1); cause_clr = '0;
        tick(4);

        // R11 code 11 ignored, code 00 cancels pending
        write_mode(2'b11);
        tick(2);
        check("R11", "code 11 ignored", 32'(cur_mode), 0);
        txn_idle = 1'b0;
        write_mode(2'b01);
        write_mode(2'b00);
        txn_idle = 1'b1;
        tick(3);
        check("R11", "pending cancelled", 32'(cur_mode), 0);

        // R4 R6 standby: line sources ignored
        write_mode(2'b10);
        check("R4", "standby enables", 32'(ens()), 0);
        check("R12", "mode standby", 32'(cur_mode), 2);
        for (int s = 0; s < 3; s++) begin
            drive_src(s, 1'b1);
            tick(6);
            check("R6", $sformatf("standby ignores src%0d", s), 32'(cur_mode), 2);
            check("R6", "no pulse", 32'({core_resume, core_restart}), 0);
            drive_src(s, 1'b0);
            tick(4);
        end
        check("R6", "no cause in standby", 32'(wake_cause), 0);

        // R9 standby wakes via VBUS and CTS with lock already present
        for (int s = 3; s < 5; s++) begin
            drive_src(s, 1'b1);
            wait_pulse(cnt, kind);
            check("R9", $sformatf("standby wake latency src%0d", s), 32'(cnt), 3 + LOCK_MIN);
            check("R9", "restart pulse", 32'(kind), 2);
            check("R10", "standby cause", 32'(wake_cause), 32'(1 << s));
            drive_src(s, 1'b0);
            cause_clr = 6'h3F; tick(1); cause_clr = '0;
            tick(4);
            write_mode(2'b10);
        end

        // R9 reset source with delayed lock
        pll_lock = 1'b0;
        ext_reset = 1'b1;
        tick(20);
        check("R9", "lock wait enables", 32'(ens()), 32'h07);
        check("R9", "lock wait mode", 32'(cur_mode), 2);
        pll_lock = 1'b1;
        tick(1);
        check("R9", "restart after lock", 32'(core_restart), 1);
        tick(1);
        check("R9", "enables back", 32'(ens()), 32'h1F);
        check("R10", "reset cause", 32'(wake_cause), 32'h20);
        ext_reset = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule